// File: doc/BRIEF.md
# Bypass Buffer with Spatial Reuse Feedback

This block is a small set-associative store for data that was deliberately kept out of the data cache. It is probed with the same address as the main cache access. On a hit it returns an element without a trip to the next memory level, so brief bursts of reuse in bypassed data are still served close to the core. Each line holds one 8-byte element. A fill is either a single element or all four elements of a 32-byte cache line, written on consecutive cycles.

Each line carries two flags. One marks spatial reuse. The other marks the element whose miss started the fetch. From these flags the buffer emits one-cycle increment and decrement events, each tagged with the 1 KiB macroblock index. An external counter table uses the events to choose between element-sized and line-sized bypass fetches for that macroblock. Fills arrive on a plain write port. The element flagged as initiator is the one the core actually missed on.

Top module: `byp_buf`

## Requirements
- R1: Address bits [9:5] select one of 32 sets of 4 ways, bits [4:3] select the element within its 32-byte cache line, bits [31:10] form the line tag, and bits [2:0] are ignored. All four elements of one cache line therefore map to the same set.
- R2: A lookup reports a hit in the same cycle when a valid line holds the addressed element, and reports no hit otherwise.
- R3: Lookup data is combinational. A fill is visible to a lookup of the same element in the following cycle, with the fill data.
- R4: A fill with the initiator flag set that allocates a new line sets that line's spatial-reuse flag when another valid line of the same cache line stays resident in the set. In that case it raises `sr_inc_o` for one cycle, in the cycle after the fill, with `sr_inc_mb_o` equal to fill address bits [31:10].
- R5: A fill with the initiator flag clear never raises `sr_inc_o`, and stores a line whose initiator flag is clear.
- R6: A lookup hit on a line whose initiator flag is clear sets that line's spatial-reuse flag. A hit on a line whose initiator flag is set leaves the flag unchanged.
- R7: When an allocating fill evicts a valid line, and no valid line of the victim's cache line (the victim included) has its spatial-reuse flag set, `sr_dec_o` pulses in the next cycle. `sr_dec_mb_o` then equals bits [31:10] of the victim's address.
- R8: Allocation takes the lowest-numbered invalid way, otherwise the least recently used way. Fills and lookup hits both count as use.
- R9: A fill to an element already resident overwrites its data in place. It allocates nothing, evicts nothing and keeps that line's flags.
- R10: When a fill and a lookup occur in the same cycle, the lookup still returns its result, but it changes neither recency nor any spatial-reuse flag.
- R11: After reset every line is invalid, no lookup hits and both event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Lookup byte address |
| lk_hit_o | output | 1 | Lookup hit, same cycle |
| lk_data_o | output | 64 | Element data on a hit |
| fill_valid_i | input | 1 | Fill write strobe |
| fill_addr_i | input | 32 | Fill element address |
| fill_data_i | input | 64 | Fill element data |
| fill_init_i | input | 1 | This element caused the fetch |
| sr_inc_o | output | 1 | Spatial counter increment event |
| sr_inc_mb_o | output | 22 | Macroblock index for the increment |
| sr_dec_o | output | 1 | Spatial counter decrement event |
| sr_dec_mb_o | output | 22 | Macroblock index for the decrement |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 64-bit elements, 128 entries in 4 ways, 32-byte lines and 1 KiB macroblocks. Random addresses are confined to two sets and six line tags. This keeps full sets, line-sized fills that displace a whole set, and victims whose siblings hold or lack the spatial flag frequent, so both event kinds occur many times. Directed sequences cover in-place overwrite, a lookup that coincides with a fill, and least-recently-used choice after a hit.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned BB_ADDR_W     = 32;
  localparam int unsigned BB_DATA_W     = 64;
  localparam int unsigned BB_WAYS       = 4;
  localparam int unsigned BB_ENTRIES    = 128;
  localparam int unsigned BB_LINE_BYTES = 32;
  localparam int unsigned BB_MB_BYTES   = 1024;
endpackage

// File: rtl/bb_match.sv
module bb_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  parameter int EL_W  = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  ltag_i,
  input  logic [WAYS-1:0][EL_W-1:0]   elem_i,
  input  logic [TAG_W-1:0]            key_ltag_i,
  input  logic [EL_W-1:0]             key_elem_i,
  output logic [WAYS-1:0]             hit_o,
  output logic [WAYS-1:0]             sib_o,
  output logic                        any_o,
  output logic [WAY_W-1:0]            idx_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic same_line;
    assign same_line = valid_i[g] && (ltag_i[g] == key_ltag_i);
    assign hit_o[g]  = same_line && (elem_i[g] == key_elem_i);
    assign sib_o[g]  = same_line && (elem_i[g] != key_elem_i);
  end

  assign any_o = |hit_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < WAYS; i++)
      if (hit_o[i]) idx_o = WAY_W'(i);
  end
endmodule

// File: rtl/bb_age.sv
module bb_age #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] age_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAY_W-1:0]           touch_i,
  output logic [WAYS-1:0][WAY_W-1:0] age_o,
  output logic [WAY_W-1:0]           victim_o
);
  logic found;

  // lowest invalid way first, else the oldest way
  always_comb begin
    victim_o = '0;
    found    = 1'b0;
    for (int i = 0; i < WAYS; i++)
      if (!valid_i[i] && !found) begin
        victim_o = WAY_W'(i);
        found    = 1'b1;
      end
    if (!found)
      for (int i = 0; i < WAYS; i++)
        if (age_i[i] == WAY_W'(WAYS-1)) victim_o = WAY_W'(i);
  end

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == touch_i)            age_o[i] = '0;
      else if (age_i[i] < age_i[touch_i])  age_o[i] = age_i[i] + WAY_W'(1);
      else                                 age_o[i] = age_i[i];
    end
  end
endmodule

// File: rtl/byp_buf.sv
module byp_buf #(
  parameter int ADDR_W     = bb_pkg::BB_ADDR_W,
  parameter int DATA_W     = bb_pkg::BB_DATA_W,
  parameter int WAYS       = bb_pkg::BB_WAYS,
  parameter int ENTRIES    = bb_pkg::BB_ENTRIES,
  parameter int LINE_BYTES = bb_pkg::BB_LINE_BYTES,
  parameter int MB_BYTES   = bb_pkg::BB_MB_BYTES,
  localparam int MB_W      = ADDR_W - $clog2(MB_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_init_i,
  output logic              sr_inc_o,
  output logic [MB_W-1:0]   sr_inc_mb_o,
  output logic              sr_dec_o,
  output logic [MB_W-1:0]   sr_dec_mb_o
);
  localparam int ELEM_OFF = $clog2(DATA_W/8);
  localparam int LINE_OFF = $clog2(LINE_BYTES);
  localparam int EL_W     = LINE_OFF - ELEM_OFF;
  localparam int SETS     = ENTRIES / WAYS;
  localparam int SET_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - LINE_OFF - SET_W;
  localparam int MB_OFF   = $clog2(MB_BYTES);
  localparam int WAY_W    = $clog2(WAYS);

  logic [SETS-1:0][WAYS-1:0]             vld_q, sr_q, fi_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  ltag_q;
  logic [SETS-1:0][WAYS-1:0][EL_W-1:0]   elem_q;
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  age_q;
  logic [DATA_W-1:0]                     data_q [SETS][WAYS];

  // address split
  logic [SET_W-1:0] lk_set, fl_set, t_set;
  logic [TAG_W-1:0] lk_lt, fl_lt;
  logic [EL_W-1:0]  lk_el, fl_el;
  assign lk_set = lk_addr_i[LINE_OFF +: SET_W];
  assign lk_lt  = lk_addr_i[ADDR_W-1 -: TAG_W];
  assign lk_el  = lk_addr_i[ELEM_OFF +: EL_W];
  assign fl_set = fill_addr_i[LINE_OFF +: SET_W];
  assign fl_lt  = fill_addr_i[ADDR_W-1 -: TAG_W];
  assign fl_el  = fill_addr_i[ELEM_OFF +: EL_W];

  logic unused_low_bits;
  assign unused_low_bits = ^{lk_addr_i[ELEM_OFF-1:0], fill_addr_i[ELEM_OFF-1:0]};

  // lookup compare
  logic [WAYS-1:0]  lk_hv, lk_sib_unused;
  logic             lk_any;
  logic [WAY_W-1:0] lk_idx;
  bb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .EL_W(EL_W)) u_lk_match (
    .valid_i(vld_q[lk_set]), .ltag_i(ltag_q[lk_set]), .elem_i(elem_q[lk_set]),
    .key_ltag_i(lk_lt), .key_elem_i(lk_el),
    .hit_o(lk_hv), .sib_o(lk_sib_unused), .any_o(lk_any), .idx_o(lk_idx)
  );
  assign lk_hit_o  = lk_valid_i & lk_any;
  assign lk_data_o = data_q[lk_set][lk_idx];

  // fill compare: resident element and siblings of the incoming line
  logic [WAYS-1:0]  fl_hv_unused, fl_sib;
  logic             fl_any;
  logic [WAY_W-1:0] fl_idx;
  bb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .EL_W(EL_W)) u_fl_match (
    .valid_i(vld_q[fl_set]), .ltag_i(ltag_q[fl_set]), .elem_i(elem_q[fl_set]),
    .key_ltag_i(fl_lt), .key_elem_i(fl_el),
    .hit_o(fl_hv_unused), .sib_o(fl_sib), .any_o(fl_any), .idx_o(fl_idx)
  );

  // recency and victim for the set touched this cycle
  logic [WAYS-1:0][WAY_W-1:0] age_nxt;
  logic [WAY_W-1:0]           victim, touch_way, fl_way;
  assign t_set     = fill_valid_i ? fl_set : lk_set;
  assign fl_way    = fl_any ? fl_idx : victim;
  assign touch_way = fill_valid_i ? fl_way : lk_idx;
  bb_age #(.WAYS(WAYS)) u_age (
    .age_i(age_q[t_set]), .valid_i(vld_q[t_set]), .touch_i(touch_way),
    .age_o(age_nxt), .victim_o(victim)
  );

  // victim's cache line: does any member carry spatial reuse
  logic             vic_vld;
  logic [TAG_W-1:0] vic_lt;
  logic [EL_W-1:0]  vic_el;
  logic [WAYS-1:0]  vm_hit, vm_sib;
  logic             vm_any_unused;
  logic [WAY_W-1:0] vm_idx_unused;
  assign vic_vld = vld_q[fl_set][victim];
  assign vic_lt  = ltag_q[fl_set][victim];
  assign vic_el  = elem_q[fl_set][victim];
  bb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .EL_W(EL_W)) u_vic_match (
    .valid_i(vld_q[fl_set]), .ltag_i(ltag_q[fl_set]), .elem_i(elem_q[fl_set]),
    .key_ltag_i(vic_lt), .key_elem_i(vic_el),
    .hit_o(vm_hit), .sib_o(vm_sib), .any_o(vm_any_unused), .idx_o(vm_idx_unused)
  );

  logic            alloc, inc_evt, dec_evt;
  logic [WAYS-1:0] vic_mask;
  logic [ADDR_W-1:0] vic_addr;
  assign alloc    = fill_valid_i & ~fl_any;
  assign vic_mask = WAYS'(1) << victim;
  assign inc_evt  = alloc & fill_init_i & |(fl_sib & ~vic_mask);
  assign dec_evt  = alloc & vic_vld & ~|((vm_hit | vm_sib) & sr_q[fl_set]);
  assign vic_addr = {vic_lt, fl_set, vic_el, {ELEM_OFF{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      sr_q   <= '0;
      fi_q   <= '0;
      ltag_q <= '0;
      elem_q <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (fill_valid_i) begin
      age_q[fl_set] <= age_nxt;
      if (!fl_any) begin
        vld_q[fl_set][fl_way]  <= 1'b1;
        ltag_q[fl_set][fl_way] <= fl_lt;
        elem_q[fl_set][fl_way] <= fl_el;
        sr_q[fl_set][fl_way]   <= inc_evt;
        fi_q[fl_set][fl_way]   <= fill_init_i;
      end
    end else if (lk_hit_o) begin
      age_q[lk_set] <= age_nxt;
      if (!fi_q[lk_set][lk_idx]) sr_q[lk_set][lk_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_valid_i) data_q[fl_set][fl_way] <= fill_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_inc_o    <= 1'b0;
      sr_dec_o    <= 1'b0;
      sr_inc_mb_o <= '0;
      sr_dec_mb_o <= '0;
    end else begin
      sr_inc_o    <= inc_evt;
      sr_dec_o    <= dec_evt;
      sr_inc_mb_o <= fill_addr_i[ADDR_W-1:MB_OFF];
      sr_dec_mb_o <= vic_addr[ADDR_W-1:MB_OFF];
    end
  end
endmodule

// File: rtl/byp_buf_chk.sv
module byp_buf_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int MB_W   = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [ADDR_W-1:0] lk_addr_i,
  input logic              lk_hit_o,
  input logic [DATA_W-1:0] lk_data_o,
  input logic              fill_valid_i,
  input logic [ADDR_W-1:0] fill_addr_i,
  input logic [DATA_W-1:0] fill_data_i,
  input logic              fill_init_i,
  input logic              sr_inc_o,
  input logic [MB_W-1:0]   sr_inc_mb_o,
  input logic              sr_dec_o,
  input logic [MB_W-1:0]   sr_dec_mb_o
);
  localparam int EO = $clog2(DATA_W/8);

  logic unused_mb;
  assign unused_mb = ^{sr_inc_mb_o, sr_dec_mb_o};

  assert_inc_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_inc_o |-> $past(fill_valid_i && fill_init_i));

  assert_no_inc_follower_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !fill_init_i) |=> !sr_inc_o);

  assert_dec_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_dec_o |-> $past(fill_valid_i));

  assert_fill_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fill_valid_i) && lk_valid_i &&
     lk_addr_i[ADDR_W-1:EO] == $past(fill_addr_i[ADDR_W-1:EO]))
    |-> (lk_hit_o && lk_data_o == $past(fill_data_i)));

  assert_overwrite_no_evict_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && lk_valid_i && lk_hit_o &&
     lk_addr_i[ADDR_W-1:EO] == fill_addr_i[ADDR_W-1:EO]) |=> !sr_dec_o);
endmodule

bind byp_buf byp_buf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MB_W(MB_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i),
  .lk_hit_o(lk_hit_o), .lk_data_o(lk_data_o), .fill_valid_i(fill_valid_i),
  .fill_addr_i(fill_addr_i), .fill_data_i(fill_data_i), .fill_init_i(fill_init_i),
  .sr_inc_o(sr_inc_o), .sr_inc_mb_o(sr_inc_mb_o), .sr_dec_o(sr_dec_o),
  .sr_dec_mb_o(sr_dec_mb_o)
);

// File: tb/sim_byp_buf.sv
module sim_byp_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkv = 1'b0, fv = 1'b0, finit = 1'b0;
  logic [31:0] lka = '0, fa = '0;
  logic [63:0] fd = '0;
  logic        hit, inc, dec;
  logic [63:0] rdata;
  logic [21:0] inc_mb, dec_mb;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  byp_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(lkv), .lk_addr_i(lka),
    .lk_hit_o(hit), .lk_data_o(rdata), .fill_valid_i(fv), .fill_addr_i(fa),
    .fill_data_i(fd), .fill_init_i(finit), .sr_inc_o(inc), .sr_inc_mb_o(inc_mb),
    .sr_dec_o(dec), .sr_dec_mb_o(dec_mb)
  );

  // reference state: 32 sets x 4 ways
  bit          m_v  [32][4];
  bit          m_sr [32][4];
  bit          m_fi [32][4];
  bit [21:0]   m_lt [32][4];
  bit [1:0]    m_el [32][4];
  bit [63:0]   m_d  [32][4];
  int          m_st [32][4];
  int          tick = 0;
  bit          p_inc = 0, p_dec = 0;
  bit [21:0]   p_inc_mb = '0, p_dec_mb = '0;

  function automatic bit [31:0] mka(bit [21:0] lt, bit [4:0] s, bit [1:0] el, bit [2:0] off);
    return {lt, s, el, off};
  endfunction

  function automatic int find(bit [31:0] a);
    for (int w = 0; w < 4; w++)
      if (m_v[a[9:5]][w] && m_lt[a[9:5]][w] == a[31:10] && m_el[a[9:5]][w] == a[4:3])
        return w;
    return -1;
  endfunction

  function automatic int pick_victim(bit [4:0] s);
    int best = 0;
    for (int w = 0; w < 4; w++) if (!m_v[s][w]) return w;
    for (int w = 1; w < 4; w++) if (m_st[s][w] < m_st[s][best]) best = w;
    return best;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_update(bit l_v, bit [31:0] l_a, bit f_v, bit [31:0] f_a,
                              bit [63:0] f_d, bit f_i);
    bit [4:0] s;
    int w, v;
    bit keep, sib;
    p_inc = 0; p_dec = 0;
    tick++;
    if (f_v) begin
      s = f_a[9:5];
      w = find(f_a);
      if (w >= 0) begin
        m_d[s][w] = f_d; m_st[s][w] = tick;
      end else begin
        v = pick_victim(s);
        if (m_v[s][v]) begin
          keep = 0;
          for (int j = 0; j < 4; j++)
            if (m_v[s][j] && m_lt[s][j] == m_lt[s][v] && m_sr[s][j]) keep = 1;
          if (!keep) begin
            p_dec = 1;
            p_dec_mb = m_lt[s][v];
          end
        end
        sib = 0;
        for (int j = 0; j < 4; j++)
          if (j != v && m_v[s][j] && m_lt[s][j] == f_a[31:10]) sib = 1;
        p_inc = f_i && sib;
        p_inc_mb = f_a[31:10];
        m_v[s][v] = 1; m_lt[s][v] = f_a[31:10]; m_el[s][v] = f_a[4:3];
        m_sr[s][v] = p_inc; m_fi[s][v] = f_i; m_d[s][v] = f_d; m_st[s][v] = tick;
      end
    end else if (l_v) begin
      w = find(l_a);
      if (w >= 0) begin
        s = l_a[9:5];
        m_st[s][w] = tick;
        if (!m_fi[s][w]) m_sr[s][w] = 1;
      end
    end
  endtask

  // one cycle: drive, check combinational and registered outputs, advance model
  task automatic step(bit l_v, bit [31:0] l_a, bit f_v, bit [31:0] f_a,
                      bit [63:0] f_d, bit f_i, string tag);
    int w;
    lkv = l_v; lka = l_a; fv = f_v; fa = f_a; fd = f_d; finit = f_i;
    #1;
    w = l_v ? find(l_a) : -1;
    check(tag, "hit", hit, 64'(w >= 0));
    if (w >= 0) check(tag, "data", rdata, m_d[l_a[9:5]][w]);
    check(tag, "inc", inc, 64'(p_inc));
    if (p_inc) check(tag, "inc_mb", inc_mb, 64'(p_inc_mb));
    check(tag, "dec", dec, 64'(p_dec));
    if (p_dec) check(tag, "dec_mb", dec_mb, 64'(p_dec_mb));
    model_update(l_v, l_a, f_v, f_a, f_d, f_i);
    @(negedge clk);
  endtask

  task automatic fill_line(bit [21:0] lt, bit [4:0] s, bit [1:0] req, bit with_lk,
                           bit [31:0] l_a, string tag);
    step(with_lk, l_a, 1, mka(lt, s, req, 3'd0), {$urandom, $urandom}, 1, tag);
    for (int e = 0; e < 4; e++)
      if (e[1:0] != req)
        step(with_lk, l_a, 1, mka(lt, s, e[1:0], 3'd0), {$urandom, $urandom}, 0, tag);
  endtask

  function automatic bit [31:0] rnd_addr();
    bit [4:0] s = ($urandom % 2) ? 5'd3 : 5'd17;
    return mka(22'($urandom % 6), s, 2'($urandom), 3'($urandom));
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: empty after reset
    step(1, mka(22'd1, 5'd3, 2'd0, 3'd0), 0, '0, '0, 0, "R11");
    step(1, mka(22'd0, 5'd0, 2'd0, 3'd0), 0, '0, '0, 0, "R11");

    // R1 R3: single fill, lookup with other low bits and via a different set
    step(0, '0, 1, mka(22'd1, 5'd3, 2'd2, 3'd0), 64'hA5A5_0001_0000_0002, 1, "R3");
    step(1, mka(22'd1, 5'd3, 2'd2, 3'd7), 0, '0, '0, 0, "R1");
    step(1, mka(22'd1, 5'd4, 2'd2, 3'd0), 0, '0, '0, 0, "R1");

    // R4: initiator fill of a sibling element of the resident line
    step(0, '0, 1, mka(22'd1, 5'd3, 2'd0, 3'd0), 64'h11, 1, "R4");
    step(0, '0, 0, '0, '0, 0, "R4");

    // R5: line-sized fill, followers carry a cleared initiator flag
    fill_line(22'd2, 5'd17, 2'd1, 0, '0, "R5");
    step(0, '0, 0, '0, '0, 0, "R5");

    // R6: hit follower element (sets reuse), hit initiator element (no change)
    step(1, mka(22'd2, 5'd17, 2'd2, 3'd0), 0, '0, '0, 0, "R6");
    step(1, mka(22'd2, 5'd17, 2'd1, 3'd0), 0, '0, '0, 0, "R6");
    // R7 R8: evict the whole line with four fresh lines; events as predicted
    for (int k = 0; k < 4; k++)
      step(0, '0, 1, mka(22'(10 + k), 5'd17, 2'd0, 3'd0), 64'(k), 1, "R7");
    step(0, '0, 0, '0, '0, 0, "R7");

    // R8: touch oldest way, next allocation takes the following oldest
    step(1, mka(22'd10, 5'd17, 2'd0, 3'd0), 0, '0, '0, 0, "R8");
    step(0, '0, 1, mka(22'd20, 5'd17, 2'd0, 3'd0), 64'h20, 1, "R8");
    step(1, mka(22'd11, 5'd17, 2'd0, 3'd0), 0, '0, '0, 0, "R8");
    step(1, mka(22'd10, 5'd17, 2'd0, 3'd0), 0, '0, '0, 0, "R8");

    // R9: overwrite in place while the same element is looked up
    step(1, mka(22'd20, 5'd17, 2'd0, 3'd0), 1, mka(22'd20, 5'd17, 2'd0, 3'd0),
         64'hDEAD_BEEF, 0, "R9");
    step(1, mka(22'd20, 5'd17, 2'd0, 3'd0), 0, '0, '0, 0, "R9");
    step(1, mka(22'd12, 5'd17, 2'd0, 3'd0), 0, '0, '0, 0, "R9");

    // R10: lookup hit on a follower line during a fill changes nothing
    fill_line(22'd30, 5'd9, 2'd0, 0, '0, "R10");
    step(1, mka(22'd30, 5'd9, 2'd3, 3'd0), 1, mka(22'd30, 5'd9, 2'd1, 3'd0), 64'h5, 0, "R10");
    for (int k = 0; k < 4; k++)
      step(0, '0, 1, mka(22'(40 + k), 5'd9, 2'd0, 3'd0), 64'(k), 1, "R10");
    step(0, '0, 0, '0, '0, 0, "R10");

    // random mix, all requirements against the reference state
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 10;
      if (r < 4)
        step(1, rnd_addr(), 0, '0, '0, 0, "R2 R3 R6 R8");
      else if (r < 6)
        step($urandom % 2, rnd_addr(), 1, rnd_addr(), {$urandom, $urandom}, 1, "R4 R7 R10");
      else if (r < 7) begin
        bit [31:0] a = rnd_addr();
        fill_line(a[31:10], a[9:5], a[4:3], $urandom % 2, rnd_addr(), "R5 R7 R9");
      end else
        step(1, rnd_addr(), 1, rnd_addr(), {$urandom, $urandom}, $urandom % 2, "R2 R9 R10");
    end
    step(0, '0, 0, '0, '0, 0, "R4 R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule